// File: doc/BRIEF.md
# Coprocessor register-transfer handshake unit

This unit sits on the coprocessor side of a processor-to-coprocessor link and follows single-register transfers through the core's pipeline. A transfer moves one 32-bit word either into a coprocessor register (move-to) or out of one (move-from). The core announces an instruction by pulling an active-low request strobe while it drives the instruction word. The unit decides whether the word belongs to it and answers with a decode-stage handshake in the next cycle, which is the issue cycle. It then stretches the execute stage with WAIT responses on a second handshake bus before it ends with LAST.

Once LAST has been given, the instruction is committed and the memory and write stages follow at fixed cycles. A move-from presents register data only during the memory stage. A move-to captures the core's data during the write stage. If the condition check fails, or a late cancel arrives before commit, the tracked instruction is dropped without touching any register. Sixteen 32-bit registers are held inside the unit.

Top module: `cpxfer_unit`

## Requirements
- R1: After reset both handshake outputs read 2'b00 (ABSENT), cpData reads zero and all sixteen internal registers hold zero.
- R2: A word seen while the unit is idle and reqN is low is claimed when instr[11:8] equals the CP_NUM parameter. In the cycle after such a claim, hsDecode reads 2'b10 (GO). An unclaimed word leaves both handshakes at 2'b00. hsDecode takes no value other than 2'b00 and 2'b10.
- R3: A claimed instruction proceeds to execute only if reqN is low and passCond is high in the issue cycle. Otherwise it is dropped, and both handshakes read 2'b00 from the next cycle on.
- R4: The busy count is given by instr[1:0]. In the cycles after the issue cycle, hsExec reads 2'b01 (WAIT) for that many cycles, then 2'b11 (LAST) for one cycle, then 2'b00.
- R5: For a move-from (instr[20]=1), cpData carries register instr[19:16] in the cycle right after LAST and is zero in every other cycle.
- R6: For a move-to (instr[20]=0), the unit writes the coreData value present in the second cycle after LAST into register instr[19:16]. coreData in any other cycle changes no register.
- R7: A high lateCancel in the issue cycle or in any cycle where hsExec is non-zero (LAST included) drops the instruction. hsExec then reads 2'b00 in the next cycle, no data appears on cpData and no register changes. A lateCancel after LAST has no effect.
- R8: Only one instruction is tracked at a time. reqN low from the first execute cycle through the write stage is not taken as a new decode. A new decode is accepted from the cycle after the write stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqN | input | 1 | Active-low request strobe: decode, then issue |
| instr | input | 32 | Instruction word from the core |
| passCond | input | 1 | Condition check passed, read in the issue cycle |
| lateCancel | input | 1 | Drops the tracked instruction before commit |
| coreData | input | DATA_W | Core register data for move-to, read in the write stage |
| hsDecode | output | 2 | Decode-stage handshake, driven in the issue cycle |
| hsExec | output | 2 | Execute-stage handshake: WAIT or LAST |
| cpData | output | DATA_W | Move-from data, non-zero only in the memory stage |

## Verification
The bench builds the unit with CP_NUM set to 10 and the default 32-bit data width and two-bit busy field. This lets the stimulus reach every busy count from 0 to 3 and all sixteen registers. Foreign words use any of the other fifteen coprocessor numbers. Random transfers are mixed with failed condition checks and with cancels placed in the issue cycle, in each WAIT cycle and in the LAST cycle. Stray request strobes are driven while an instruction is in flight. A register model then shows that a dropped move-to leaves its register unchanged.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  typedef enum logic [1:0] {
    HS_ABSENT = 2'b00,
    HS_WAIT   = 2'b01,
    HS_GO     = 2'b10,
    HS_LAST   = 2'b11
  } hs_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rdLoad;   // latch selected register onto cpData
    logic rdClear;  // return cpData to zero
    logic wrEn;     // write coreData into selected register
  } strobe_t;
endpackage

// File: rtl/cpx_ctrl.sv
module cpx_ctrl
  import cpx_pkg::*;
#(
  parameter int CP_NUM = 7,
  parameter int BUSY_W = 2,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqN,
  input  logic [31:0]      instr,
  input  logic             passCond,
  input  logic             lateCancel,
  output hs_e              hsDecode,
  output hs_e              hsExec,
  output strobe_t          stb,
  output logic [IDX_W-1:0] regIdx
);
  localparam logic [3:0] OwnNum = 4'(CP_NUM);

  typedef enum logic [2:0] {ST_IDLE, ST_ISSUE, ST_EXEC, ST_MEM, ST_WRITE} st_e;

  st_e               state;
  logic              dirFrom;
  logic [BUSY_W-1:0] busyLeft;
  logic              claim;
  logic              busyDone;

  assign claim    = !reqN && (instr[11:8] == OwnNum);
  assign busyDone = (busyLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dirFrom  <= 1'b0;
      regIdx   <= '0;
      busyLeft <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (claim) begin
          state    <= ST_ISSUE;
          dirFrom  <= instr[20];
          regIdx   <= instr[16 +: IDX_W];
          busyLeft <= instr[BUSY_W-1:0];
        end
        ST_ISSUE: state <= (!reqN && passCond && !lateCancel) ? ST_EXEC : ST_IDLE;
        ST_EXEC: begin
          if (lateCancel)     state    <= ST_IDLE;
          else if (!busyDone) busyLeft <= busyLeft - 1'b1;
          else                state    <= ST_MEM;
        end
        ST_MEM:   state <= ST_WRITE;
        ST_WRITE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    hsDecode    = (state == ST_ISSUE) ? HS_GO : HS_ABSENT;
    hsExec      = (state != ST_EXEC) ? HS_ABSENT : (busyDone ? HS_LAST : HS_WAIT);
    stb.rdLoad  = (state == ST_EXEC) && busyDone && !lateCancel && dirFrom;
    stb.rdClear = (state == ST_MEM);
    stb.wrEn    = (state == ST_WRITE) && !dirFrom;
  end
endmodule

// File: rtl/cpx_dpath.sv
module cpx_dpath
  import cpx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] coreData,
  output logic [DATA_W-1:0] cpData
);
  localparam int NRegs = 1 << IDX_W;

  logic [DATA_W-1:0] regs [NRegs];

  for (genvar g = 0; g < NRegs; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       regs[g] <= '0;
      else if (stb.wrEn && (regIdx == IDX_W'(g)))      regs[g] <= coreData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cpData <= '0;
    else if (stb.rdClear) cpData <= '0;
    else if (stb.rdLoad)  cpData <= regs[regIdx];
  end
endmodule

// File: rtl/cpxfer_unit.sv
module cpxfer_unit
  import cpx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CP_NUM = 7,
  parameter int BUSY_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqN,
  input  logic [31:0]       instr,
  input  logic              passCond,
  input  logic              lateCancel,
  input  logic [DATA_W-1:0] coreData,
  output logic [1:0]        hsDecode,
  output logic [1:0]        hsExec,
  output logic [DATA_W-1:0] cpData
);
  localparam int IdxW = 4;  // register select sits in instr[19:16]

  hs_e            decHs;
  hs_e            exeHs;
  strobe_t        stb;
  logic [IdxW-1:0] regIdx;

  cpx_ctrl #(.CP_NUM(CP_NUM), .BUSY_W(BUSY_W), .IDX_W(IdxW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqN(reqN), .instr(instr),
    .passCond(passCond), .lateCancel(lateCancel),
    .hsDecode(decHs), .hsExec(exeHs), .stb(stb), .regIdx(regIdx)
  );

  cpx_dpath #(.DATA_W(DATA_W), .IDX_W(IdxW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .regIdx(regIdx),
    .coreData(coreData), .cpData(cpData)
  );

  assign hsDecode = decHs;
  assign hsExec   = exeHs;
endmodule

// File: rtl/cpx_checker.sv
module cpx_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqN,
  input logic              passCond,
  input logic              lateCancel,
  input logic [1:0]        hsDecode,
  input logic [1:0]        hsExec,
  input logic [DATA_W-1:0] cpData
);
  a_r2_decode_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (hsDecode != 2'b00) |-> $past(!reqN));

  a_r2_decode_values: assert property (@(posedge clk) disable iff (!rstN)
    (hsDecode == 2'b00) || (hsDecode == 2'b10));

  a_r3_issue_gated: assert property (@(posedge clk) disable iff (!rstN)
    (hsDecode == 2'b10 && (reqN || !passCond)) |=> (hsExec == 2'b00 && hsDecode == 2'b00));

  a_r4_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    (hsExec == 2'b11) |=> (hsExec == 2'b00));

  a_r4_wait_continues: assert property (@(posedge clk) disable iff (!rstN)
    (hsExec == 2'b01 && !lateCancel) |=> (hsExec != 2'b00));

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (cpData != '0) |=> (cpData == '0));

  a_r5_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (cpData != '0) |-> ($past(hsExec) == 2'b11));

  a_r7_cancel_drops: assert property (@(posedge clk) disable iff (!rstN)
    (hsExec != 2'b00 && lateCancel) |=> (hsExec == 2'b00 && cpData == '0));

  a_r8_one_stage: assert property (@(posedge clk) disable iff (!rstN)
    !(hsDecode != 2'b00 && hsExec != 2'b00));
endmodule

bind cpxfer_unit cpx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqN(reqN), .passCond(passCond),
  .lateCancel(lateCancel), .hsDecode(hsDecode), .hsExec(hsExec), .cpData(cpData)
);

// File: tb/cpxfer_unit_test.sv
module cpxfer_unit_test;
  localparam int CPN = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqN = 1'b1;
  logic [31:0] instr = '0;
  logic        passCond = 1'b0;
  logic        lateCancel = 1'b0;
  logic [31:0] coreData = '0;
  logic [1:0]  hsDecode;
  logic [1:0]  hsExec;
  logic [31:0] cpData;

  int vecs = 0;
  int errs = 0;
  logic [31:0] mdl [16];

  always #5 clk = ~clk;

  cpxfer_unit #(.DATA_W(32), .CP_NUM(CPN), .BUSY_W(2)) uut (
    .clk(clk), .rstN(rstN), .reqN(reqN), .instr(instr), .passCond(passCond),
    .lateCancel(lateCancel), .coreData(coreData),
    .hsDecode(hsDecode), .hsExec(hsExec), .cpData(cpData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mkWord(input bit from, input logic [3:0] idx,
                                         input logic [3:0] cp, input logic [1:0] busy);
    return {11'h3A5, from, idx, 4'h6, cp, 6'h1D, busy};
  endfunction

  // expected execute handshake in execute cycle k (1-based) with n busy cycles
  function automatic logic [1:0] expExec(input int k, input int n);
    return (k <= n) ? 2'b01 : 2'b11;
  endfunction

  function automatic logic [3:0] foreignCp();
    return 4'((CPN + 1 + ($urandom % 15)) % 16);
  endfunction

  task automatic idleCheck(input string req);
    @(negedge clk);
    reqN = 1'b1; passCond = 1'b0; lateCancel = 1'b0; coreData = $urandom;
    chk(hsDecode == 2'b00, req, {30'd0, hsDecode}, 32'd0);
    chk(hsExec == 2'b00, req, {30'd0, hsExec}, 32'd0);
    chk(cpData == '0, req, cpData, 32'd0);
  endtask

  // cancelAt: -1 none, 0 issue cycle, k>=1 execute cycle k
  task automatic runXfer(input logic [31:0] word, input bit passBit, input int cancelAt);
    bit   owned = (word[11:8] == 4'(CPN));
    int   n     = int'(word[1:0]);
    int   idx   = int'(word[19:16]);
    bit   from  = word[20];
    logic [31:0] d;
    @(negedge clk);
    reqN = 1'b0; instr = word; passCond = 1'b0; lateCancel = 1'b0; coreData = $urandom;
    @(negedge clk);
    chk(hsDecode == (owned ? 2'b10 : 2'b00), "R2 decode response", {30'd0, hsDecode},
        owned ? 32'd2 : 32'd0);
    if (!owned) begin
      reqN = 1'b1;
      idleCheck("R2 foreign word ignored");
      return;
    end
    reqN = 1'b0; passCond = passBit; lateCancel = (cancelAt == 0);
    chk(hsExec == 2'b00, "R4 no exec during issue", {30'd0, hsExec}, 32'd0);
    if (!passBit || cancelAt == 0) begin
      idleCheck(!passBit ? "R3 failed pass drops" : "R7 cancel at issue drops");
      idleCheck("R6 dropped transfer quiet");
      idleCheck("R6 dropped transfer quiet");
      return;
    end
    for (int k = 1; k <= n + 1; k++) begin
      @(negedge clk);
      reqN = 1'($urandom % 2); instr = word; passCond = 1'($urandom % 2);
      lateCancel = (cancelAt == k); coreData = $urandom;
      chk(hsExec == expExec(k, n), "R4 execute handshake", {30'd0, hsExec},
          {30'd0, expExec(k, n)});
      chk(hsDecode == 2'b00, "R8 no new decode in execute", {30'd0, hsDecode}, 32'd0);
      if (cancelAt == k) begin
        idleCheck("R7 cancel in execute drops");
        idleCheck("R7 no data after cancel");
        idleCheck("R7 no data after cancel");
        return;
      end
    end
    @(negedge clk);  // memory stage
    reqN = 1'b0; lateCancel = 1'($urandom % 2); coreData = $urandom;
    chk(hsExec == 2'b00, "R4 handshake ends after LAST", {30'd0, hsExec}, 32'd0);
    chk(cpData == (from ? mdl[idx] : 32'd0), "R5 memory-stage data", cpData,
        from ? mdl[idx] : 32'd0);
    @(negedge clk);  // write stage
    d = $urandom; coreData = d; reqN = 1'b0; lateCancel = 1'($urandom % 2);
    chk(cpData == '0, "R5 data gone after memory stage", cpData, 32'd0);
    chk(hsDecode == 2'b00, "R8 strobe ignored in memory stage", {30'd0, hsDecode}, 32'd0);
    if (!from) mdl[idx] = d;
    idleCheck("R8 strobe ignored in write stage");
  endtask

  task automatic readAll(input string req);
    for (int r = 0; r < 16; r++) begin
      logic [31:0] w = mkWord(1'b1, 4'(r), 4'(CPN), 2'd0);
      @(negedge clk);
      reqN = 1'b0; instr = w; passCond = 1'b0; lateCancel = 1'b0;
      @(negedge clk); passCond = 1'b1;
      @(negedge clk); reqN = 1'b1; passCond = 1'b0;  // LAST cycle
      @(negedge clk);
      chk(cpData == mdl[r], req, cpData, mdl[r]);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int r = 0; r < 16; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    chk(hsDecode == 2'b00, "R1 reset decode", {30'd0, hsDecode}, 32'd0);
    chk(hsExec == 2'b00, "R1 reset exec", {30'd0, hsExec}, 32'd0);
    chk(cpData == '0, "R1 reset data", cpData, 32'd0);
    rstN = 1'b1;
    readAll("R1 registers zero after reset");

    // directed corners
    runXfer(mkWord(1'b0, 4'd15, 4'(CPN), 2'd3), 1'b1, -1);  // R6 write, longest stall
    runXfer(mkWord(1'b1, 4'd15, 4'(CPN), 2'd0), 1'b1, -1);  // R5 read, no stall
    runXfer(mkWord(1'b0, 4'd15, 4'(CPN), 2'd2), 1'b1, 3);   // R7 cancel on LAST
    runXfer(mkWord(1'b0, 4'd15, 4'(CPN), 2'd1), 1'b0, -1);  // R3 failed condition
    runXfer(mkWord(1'b0, 4'd15, foreignCp(), 2'd0), 1'b1, -1); // R2 foreign
    runXfer(mkWord(1'b1, 4'd15, 4'(CPN), 2'd3), 1'b1, 4);   // R7 read cancelled at LAST
    runXfer(mkWord(1'b1, 4'd15, 4'(CPN), 2'd1), 1'b1, -1);  // R6 value kept

    for (int t = 0; t < 300; t++) begin
      logic [3:0] cp   = ($urandom % 8 == 0) ? foreignCp() : 4'(CPN);
      logic [1:0] busy = 2'($urandom);
      bit         pb   = ($urandom % 10) != 0;
      int         ca   = ($urandom % 7 == 0) ? int'($urandom % (int'(busy) + 2)) : -1;
      runXfer(mkWord(1'($urandom), 4'($urandom), cp, busy), pb, ca);
    end
    readAll("R6 register contents match model");

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule